// File: doc/BRIEF.md
# Branch Sample Record Buffer

This block captures the source and target addresses of retired taken branches into a small register buffer with a fixed depth. Software arms it by writing a configuration word that sets the enable bit, clears the write index and names one performance counter. From then on, each accepted branch fills the next entry. The buffer fills in a single pass. When the last entry has been written, the write index returns to zero to mark the buffer full, the enable bit clears itself, and recording stops. Older entries are never overwritten.

An overflow pulse from the selected counter, arriving while recording is enabled, is not passed on at once. It is held until recording stops, either because the buffer is full or because software has cleared the enable bit. The interrupt request then pulses for one cycle. Software reads and writes the entries and the configuration word through a simple register port. Entry n has its from-address at register 2n and its to-address at register 2n+1. The configuration word sits at register 2*DEPTH.

The branch input is a valid/ready stream. `br_ready` is always high, so a beat is consumed in every cycle in which `br_valid` is high. A beat that arrives while recording is disabled, or in the same cycle as a configuration write, is consumed and dropped. The block applies no back-pressure.

Top module: `brsb_top`

## Requirements
- R1: After reset, the configuration word reads 0x0000_0000_0000_0018, every entry reads 0, and `irq_o` is low.
- R2: Register 2n holds the from-address of entry n and register 2n+1 holds its to-address (n = 0..15). Software writes to these registers read back unchanged.
- R3: While enabled, each accepted branch stores its from/to pair at the entry named by the write index (configuration bits 19:16) and advances the index by one. Both are visible after the capturing clock edge.
- R4: The valid flag (bit 5) sets on the first capture. A configuration write with enable (bit 2) set and index 0 clears the flag, whatever value bit 5 carries in that write.
- R5: Capturing into entry 15 sets the index to 0 and clears the enable bit. Branches after that point change no entry.
- R6: A branch beat that arrives while the enable bit is clear leaves every entry and the configuration word unchanged.
- R7: An overflow pulse on the counter selected by bits 26:24, arriving while enabled, keeps `irq_o` low while recording continues. `irq_o` pulses high for one cycle, one clock edge after the edge on which the enable bit cleared.
- R8: A software write that clears the enable bit while an overflow is held releases the one-cycle interrupt pulse one edge later.
- R9: An overflow on the selected counter while disabled pulses `irq_o` after the next edge. Overflows on counters that are not selected never raise `irq_o`.
- R10: Bits 4:3 of the configuration word always read as 11b. Bits 1:0, 15:6, 23:20 and 63:27 always read 0.
- R11: `br_ready` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Retired taken branch beat is present |
| br_ready | output | 1 | Beat accepted (always high) |
| br_from | input | 64 | Branch source address |
| br_to | input | 64 | Branch target address |
| ovf_pulse | input | 6 | Per-counter overflow pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register index: entries 0..31, configuration at 32 |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational from reg_addr) |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
`reg_rdata` is combinational, so a read is sampled on the falling edge within the same cycle in which its address is presented. A branch or register write takes effect at the rising edge that samples it. Read checks are therefore issued only after the task that drove the stimulus has passed that edge. `irq_o` is registered and follows the edge on which the enable bit clears. The bench expects it low at the falling edge just after that edge, high at the next falling edge, and low again one cycle later. An overflow while disabled is expected high at the first falling edge after the pulse is sampled.

// File: rtl/brsb_pkg.sv
package brsb_pkg;
  localparam int REG_W     = 64;
  localparam int EN_BIT    = 2;
  localparam int FIX_LSB   = 3;
  localparam int VALID_BIT = 5;
  localparam int IDX_LSB   = 16;
  localparam int IDX_FW    = 4;
  localparam int SEL_LSB   = 24;
  localparam int SEL_FW    = 3;

  typedef logic [REG_W-1:0]  reg_word_t;
  typedef logic [SEL_FW-1:0] ctr_sel_t;
endpackage

// File: rtl/brsb_cfg.sv
module brsb_cfg
  import brsb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  reg_word_t       cfg_wdata,
  input  logic            br_valid,
  output logic            en_o,
  output logic            valid_o,
  output logic [IDXW-1:0] idx_o,
  output ctr_sel_t        sel_o,
  output logic            cap_o
);
  localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);

  logic            en_q, valid_q;
  logic [IDXW-1:0] idx_q;
  ctr_sel_t        sel_q;
  logic            fresh;

  // a capture needs recording on and no concurrent configuration write
  assign cap_o = br_valid && en_q && !cfg_we;
  assign fresh = cfg_wdata[EN_BIT] && (cfg_wdata[IDX_LSB +: IDXW] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
      sel_q   <= '0;
    end else if (cfg_we) begin
      en_q    <= cfg_wdata[EN_BIT];
      idx_q   <= cfg_wdata[IDX_LSB +: IDXW];
      sel_q   <= cfg_wdata[SEL_LSB +: SEL_FW];
      valid_q <= fresh ? 1'b0 : cfg_wdata[VALID_BIT];
    end else if (cap_o) begin
      valid_q <= 1'b1;
      if (idx_q == LAST) begin
        idx_q <= '0;
        en_q  <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign en_o    = en_q;
  assign valid_o = valid_q;
  assign idx_o   = idx_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/brsb_store.sv
module brsb_store
  import brsb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 64,
  parameter int IDXW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [IDXW-1:0]   cap_idx,
  input  logic [ADDR_W-1:0] cap_from,
  input  logic [ADDR_W-1:0] cap_to,
  input  logic              sw_we,
  input  logic [IDXW:0]     sw_addr,
  input  logic [ADDR_W-1:0] sw_wdata,
  input  logic [IDXW:0]     rd_addr,
  output reg_word_t         rd_data
);
  localparam int EAW = IDXW + 1;

  logic [ADDR_W-1:0] from_q [DEPTH];
  logic [ADDR_W-1:0] to_q   [DEPTH];
  logic [DEPTH-1:0]  from_sw, to_sw, hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign from_sw[g] = sw_we && (sw_addr == EAW'(2 * g));
    assign to_sw[g]   = sw_we && (sw_addr == EAW'(2 * g + 1));
    assign hit[g]     = cap && (cap_idx == IDXW'(g));
  end

  // a software write to an entry wins over a capture into the same entry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        from_q[i] <= '0;
        to_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (from_sw[i])  from_q[i] <= sw_wdata;
        else if (hit[i]) from_q[i] <= cap_from;
        if (to_sw[i])    to_q[i]   <= sw_wdata;
        else if (hit[i]) to_q[i]   <= cap_to;
      end
    end
  end

  always_comb begin
    if (rd_addr[0]) rd_data = reg_word_t'(to_q[rd_addr[IDXW:1]]);
    else            rd_data = reg_word_t'(from_q[rd_addr[IDXW:1]]);
  end
endmodule

// File: rtl/brsb_irq_hold.sv
module brsb_irq_hold
  import brsb_pkg::*;
#(
  parameter int NCTR = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTR-1:0] ovf,
  input  ctr_sel_t        sel,
  input  logic            en,
  output logic            pending_o,
  output logic            irq_o
);
  logic ovf_hit, pending_q, irq_q, release_now;

  always_comb begin
    ovf_hit = 1'b0;
    for (int i = 0; i < NCTR; i++)
      if (int'(sel) == i) ovf_hit = ovf[i];
  end

  assign release_now = pending_q && !en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= release_now || (ovf_hit && !en);
      if (release_now)         pending_q <= 1'b0;
      else if (ovf_hit && en)  pending_q <= 1'b1;
    end
  end

  assign pending_o = pending_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/brsb_top.sv
module brsb_top
  import brsb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 64,
  parameter int NCTR   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  output logic              br_ready,
  input  logic [ADDR_W-1:0] br_from,
  input  logic [ADDR_W-1:0] br_to,
  input  logic [NCTR-1:0]   ovf_pulse,
  input  logic              reg_we,
  input  logic [$clog2(DEPTH)+1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_o
);
  localparam int IDXW     = $clog2(DEPTH);
  localparam int RAW      = IDXW + 2;
  localparam int CFG_ADDR = 2 * DEPTH;

  logic            cfg_we, ent_we;
  logic            en_q, valid_q, cap, pending;
  logic [IDXW-1:0] idx_q;
  ctr_sel_t        sel_q;
  reg_word_t       cfg_word, ent_rd;

  assign br_ready = 1'b1;
  assign cfg_we   = reg_we && (reg_addr == RAW'(CFG_ADDR));
  assign ent_we   = reg_we && !reg_addr[RAW-1];

  brsb_cfg #(.DEPTH(DEPTH), .IDXW(IDXW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(reg_wdata),
    .br_valid(br_valid), .en_o(en_q), .valid_o(valid_q), .idx_o(idx_q),
    .sel_o(sel_q), .cap_o(cap)
  );

  brsb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDXW(IDXW)) u_store (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_idx(idx_q),
    .cap_from(br_from), .cap_to(br_to), .sw_we(ent_we),
    .sw_addr(reg_addr[IDXW:0]), .sw_wdata(reg_wdata[ADDR_W-1:0]),
    .rd_addr(reg_addr[IDXW:0]), .rd_data(ent_rd)
  );

  brsb_irq_hold #(.NCTR(NCTR)) u_irq (
    .clk(clk), .rst_n(rst_n), .ovf(ovf_pulse), .sel(sel_q), .en(en_q),
    .pending_o(pending), .irq_o(irq_o)
  );

  always_comb begin
    cfg_word                      = '0;
    cfg_word[EN_BIT]              = en_q;
    cfg_word[FIX_LSB +: 2]        = 2'b11;
    cfg_word[VALID_BIT]           = valid_q;
    cfg_word[IDX_LSB +: IDXW]     = idx_q;
    cfg_word[SEL_LSB +: SEL_FW]   = sel_q;
  end

  always_comb begin
    if (!reg_addr[RAW-1])                reg_rdata = ent_rd;
    else if (reg_addr == RAW'(CFG_ADDR)) reg_rdata = cfg_word;
    else                                 reg_rdata = '0;
  end
endmodule

// File: rtl/brsb_checker.sv
module brsb_checker
  import brsb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            br_valid,
  input logic            br_ready,
  input logic            irq_o,
  input logic            en_q,
  input logic            valid_q,
  input logic [IDXW-1:0] idx_q,
  input logic            cap,
  input logic            cfg_we,
  input logic            pending,
  input reg_word_t       reg_wdata
);
  localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) br_ready); // R11
  AST_STEP_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && idx_q != LAST) |=> (idx_q == IDXW'($past(idx_q) + 1'b1)) && valid_q); // R3
  AST_FULL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && idx_q == LAST) |=> (!en_q && idx_q == '0)); // R5
  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !en_q && !cfg_we) |=> ($stable(idx_q) && $stable(valid_q))); // R6
  AST_FRESH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && reg_wdata[EN_BIT] && reg_wdata[IDX_LSB +: IDXW] == '0) |=> !valid_q); // R4
  AST_IRQ_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(en_q)); // R7
  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && en_q) |=> !irq_o); // R7
endmodule

bind brsb_top brsb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_ready(br_ready),
  .irq_o(irq_o), .en_q(en_q), .valid_q(valid_q), .idx_q(idx_q), .cap(cap),
  .cfg_we(cfg_we), .pending(pending), .reg_wdata(reg_wdata)
);

// File: tb/brsb_top_bench.sv
module brsb_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic        br_ready;
  logic [63:0] br_from = '0, br_to = '0;
  logic [5:0]  ovf_pulse = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq_o;

  always #4 clk = ~clk;

  brsb_top u_brsb_top (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_ready(br_ready),
    .br_from(br_from), .br_to(br_to), .ovf_pulse(ovf_pulse), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic        mon_go = 1'b0;
  localparam logic [5:0] CFG = 6'd32;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result against the queued expectation
  always @(negedge clk)
    if (mon_go && exp_q.size() > 0) check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());

  task automatic expect_rd(logic [5:0] a, logic [63:0] e, string tag);
    @(posedge clk); #1;
    reg_addr = a; exp_q.push_back(e); tag_q.push_back(tag); mon_go = 1'b1;
    @(posedge clk); #1 mon_go = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [63:0] d);
    @(posedge clk); #1 reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 1'b0;
  endtask

  task automatic branch(logic [63:0] f, logic [63:0] t);
    @(posedge clk); #1 br_valid = 1'b1; br_from = f; br_to = t;
    @(posedge clk); #1 br_valid = 1'b0;
  endtask

  task automatic ovf(int i);
    @(posedge clk); #1 ovf_pulse = 6'(1 << i);
    @(posedge clk); #1 ovf_pulse = '0;
  endtask

  task automatic irq_at(logic e, string tag);
    @(negedge clk); check(tag, 64'(irq_o), 64'(e));
  endtask

  task automatic summary;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_rd(CFG, 64'h18, "R1 cfg reset");
    expect_rd(6'd0, 64'h0, "R1 entry0 reset");
    irq_at(1'b0, "R1 irq reset");
    // R11 stream always ready
    check("R11 br_ready", 64'(br_ready), 64'h1);
    // R2 software access to entries
    wr(6'd6, 64'hAAAA_0000_1111_2222);
    wr(6'd7, 64'hBBBB_3333_4444_5555);
    expect_rd(6'd6, 64'hAAAA_0000_1111_2222, "R2 entry3 from");
    expect_rd(6'd7, 64'hBBBB_3333_4444_5555, "R2 entry3 to");
    // R6 branch while disabled
    branch(64'h1, 64'h2);
    expect_rd(6'd0, 64'h0, "R6 entry0 untouched");
    expect_rd(CFG, 64'h18, "R6 cfg untouched");
    // R4 fresh start, counter 2 selected
    wr(CFG, 64'h0200_0024);
    expect_rd(CFG, 64'h0200_001C, "R4 fresh clears valid");
    // R9 unselected counter ignored
    ovf(1);
    irq_at(1'b0, "R9 unselected a"); irq_at(1'b0, "R9 unselected b");
    // R7 selected overflow held
    ovf(2);
    irq_at(1'b0, "R7 held a"); irq_at(1'b0, "R7 held b");
    // R3 captures
    for (int i = 0; i < 3; i++) branch(64'h1000 + i, 64'h2000 + i);
    expect_rd(CFG, 64'h0203_003C, "R3 index 3 valid set");
    for (int i = 0; i < 3; i++) begin
      expect_rd(6'(2 * i), 64'h1000 + i, "R3 entry from");
      expect_rd(6'(2 * i + 1), 64'h2000 + i, "R3 entry to");
    end
    irq_at(1'b0, "R7 still held");
    for (int i = 3; i < 15; i++) branch(64'h1000 + i, 64'h2000 + i);
    irq_at(1'b0, "R7 held before last");
    branch(64'h100F, 64'h200F);
    irq_at(1'b0, "R7 irq not yet");
    irq_at(1'b1, "R7 irq released");
    irq_at(1'b0, "R7 irq one cycle");
    expect_rd(CFG, 64'h0200_0038, "R5 full index 0 enable off");
    expect_rd(6'd31, 64'h200F, "R5 last entry to");
    // R5 saturation: later branches write nothing
    branch(64'hDEAD, 64'hBEEF);
    expect_rd(6'd0, 64'h1000, "R5 entry0 kept");
    expect_rd(CFG, 64'h0200_0038, "R5 cfg kept");
    // R4 fresh start ignores valid bit in write; R8 software release
    wr(CFG, 64'h0200_0024);
    expect_rd(CFG, 64'h0200_001C, "R4 fresh with valid bit");
    ovf(2);
    branch(64'h3000, 64'h4000);
    branch(64'h3001, 64'h4001);
    irq_at(1'b0, "R8 held");
    wr(CFG, 64'h0202_0020);
    irq_at(1'b0, "R8 not yet");
    irq_at(1'b1, "R8 released by clear");
    irq_at(1'b0, "R8 one cycle");
    expect_rd(CFG, 64'h0202_0038, "R8 cfg after clear");
    // R9 overflow while disabled
    ovf(2);
    irq_at(1'b1, "R9 disabled overflow");
    irq_at(1'b0, "R9 pulse ends");
    // R10 reserved bits
    wr(CFG, 64'hFFFF_FFFF_FFFF_FFFF);
    expect_rd(CFG, 64'h0000_0000_070F_003C, "R10 reserved fields");
    // R5 capture at last index from software-set index
    branch(64'hF0, 64'hF1);
    expect_rd(6'd30, 64'hF0, "R5 entry15 from");
    expect_rd(CFG, 64'h0700_0038, "R5 saturate again");
    expect_rd(6'd33, 64'h0, "R10 unmapped reads 0");
    repeat (2) @(posedge clk);
    summary();
  end
endmodule